// File: doc/BRIEF.md
# Master/Slave Synchronized PWM Timebase

This block produces the switching-period timebase and the high-side on pulse for a digital buck-converter controller. A role input picks between two roles. As master, the block runs its own period counter and drives a square period clock onto a shared sync line. As slave, it passes the sync line through a synchronizer and restarts its period on every detected rising edge. A slave shuts its output off whenever the master clock goes missing. A master keeps driving the sync clock even while its own output is disabled, so that slaves on the same line continue to switch.

All times are counted in cycles of `clk`. The period comes from a setting word, or from a fixed default when the default-select input is high. The duty command is an on-time in clocks. It is limited so that a minimum off-time is always left in every period. The period setting and the duty command are both captured only on the first clock of a period, so a change made in the middle of a period cannot produce a runt or a stretched pulse. A one-clock cycle-start strobe marks every period for downstream fault logic. Master and slaves must be given the same period setting.

Top module: `sync_pwm_timebase`

## Requirements
- R1: While synchronous reset is held, hs_on_o is low. The first clock after release is a period start: cyc_start_o is high and hs_on_o is low. In slave role sync_lost_o is high.
- R2: The effective period in clocks is DEF_TICKS (default 30) when use_default_i=1. Otherwise it is period_i limited to the range MIN_TICKS..MAX_TICKS (defaults 20..48). cyc_start_o is high for exactly one clock, the first clock of each period.
- R3: period_i, use_default_i and duty_i are sampled only on the clock edge that begins a period. A change during a period takes effect in the following period.
- R4: The on-time of a period is min(duty, period - OFF_TICKS) clocks, with OFF_TICKS defaulting to 6. hs_on_o is high for that many clocks at the start of the period. This caps the duty at 87.5% for a 48-clock period and at 70% for a 20-clock period.
- R5: In master role (role_master_i=1), sync_oe_o=1 and sync_out_o is high for the first floor(period/2) clocks of each period. In slave role (role_master_i=0), sync_oe_o=0 and sync_out_o=0.
- R6: en_i=0 holds hs_on_o low in either role. A master with en_i=0 keeps its period running and keeps toggling sync_out_o.
- R7: In slave role, a rising edge of sync_in_i is first sampled at clock k. It restarts the period, so cyc_start_o is high in the cycle after clock k+2: two synchronizer flops plus one edge register. In master role sync_in_i has no effect.
- R8: In slave role, if no edge is detected for period + floor(period/2) clocks, sync_lost_o goes high within one further clock and hs_on_o stays low.
- R9: After reset or after a loss, a slave resumes switching only after two detected edges, the second arriving within the loss window of the first. sync_lost_o is still high after the first edge alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| role_master_i | input | 1 | 1 = master role, 0 = slave role |
| en_i | input | 1 | Output enable; 0 holds the high-side pulse off |
| use_default_i | input | 1 | 1 forces the default period |
| period_i | input | 16 | Period setting in clocks |
| duty_i | input | 16 | Requested on-time in clocks |
| sync_in_i | input | 1 | Sync line as received (used in slave role) |
| sync_out_o | output | 1 | Period clock driven onto the sync line |
| sync_oe_o | output | 1 | Drive enable for the sync line |
| hs_on_o | output | 1 | High-side on pulse |
| cyc_start_o | output | 1 | One-clock strobe at each period start |
| sync_lost_o | output | 1 | Slave has no valid sync clock |

## Verification
The hardest situation to reach is the slave's path through loss and recovery. The bench must hold the sync line quiet for longer than the loss window, restart it, and then sample the lock state in the exact cycles between the first and the second detected edge. The stimulus does this with a bench-side sync generator that can be stopped, restarted and retimed. Its period can differ from the slave's own setting, so restarts also land in the middle of a free-running count. A behavioural reference model follows the same edge history and is compared against every output on every clock. Directed checks then measure period lengths and pulse widths across the transitions.

// File: rtl/sync_pwm_pkg.sv
package sync_pwm_pkg;

    localparam int TICK_W = 16;

    typedef logic [TICK_W-1:0] tick_t;

    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } role_e;

    typedef enum logic [1:0] {
        LK_NONE = 2'd0,
        LK_ONE  = 2'd1,
        LK_OK   = 2'd2
    } lock_e;

    // Configuration captured at the start of each period
    typedef struct packed {
        tick_t period;
        tick_t on_ticks;
    } cycle_cfg_t;

    function automatic tick_t clamp_ticks(tick_t v, tick_t lo, tick_t hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic tick_t cap_on(tick_t duty, tick_t period, tick_t off);
        tick_t lim;
        lim = period - off;
        return (duty > lim) ? lim : duty;
    endfunction

endpackage

// File: rtl/sync_lock_mon.sv
module sync_lock_mon
    import sync_pwm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sync_in,
    input  tick_t period,
    output logic  edge_o,
    output logic  locked_o
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] chain_q;
    logic         last_q;
    tick_t        wd_q;
    lock_e        lk_q;
    tick_t        limit;
    logic         expired;

    generate
        if (SYNC_STAGES == 1) begin : g_one_stage
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= sync_in;
            end
        end else begin : g_multi_stage
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[MSB-1:0], sync_in};
            end
        end
    endgenerate

    assign limit   = period + (period >> 1);
    assign expired = (wd_q >= limit);
    assign edge_o  = chain_q[MSB] & ~last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= 1'b0;
            wd_q   <= '0;
            lk_q   <= LK_NONE;
        end else begin
            last_q <= chain_q[MSB];
            if (edge_o) begin
                wd_q <= '0;
                if (expired || lk_q == LK_NONE) lk_q <= LK_ONE;
                else                            lk_q <= LK_OK;
            end else if (expired) begin
                lk_q <= LK_NONE;
            end else begin
                wd_q <= wd_q + tick_t'(1);
            end
        end
    end

    assign locked_o = (lk_q == LK_OK);

    // R9: lock is only ever gained on a detected edge
    p_lock_on_edge_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_o) |-> $past(edge_o));

    // R8: a full window without an edge drops the lock
    p_timeout_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (expired && !edge_o) |=> !locked_o);

endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr
    import sync_pwm_pkg::*;
#(
    parameter int DEF_TICKS = 30,
    parameter int OFF_TICKS = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart_i,
    input  tick_t      req_period_i,
    input  tick_t      duty_i,
    output tick_t      cnt_o,
    output cycle_cfg_t cfg_o
);
    localparam tick_t OFF = tick_t'(OFF_TICKS);
    localparam tick_t DEF = tick_t'(DEF_TICKS);

    tick_t      cnt_q;
    cycle_cfg_t cfg_q;
    logic       wrap;

    assign wrap = restart_i || (cnt_q >= cfg_q.period - tick_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q          <= '0;
            cfg_q.period   <= DEF;
            cfg_q.on_ticks <= '0;
        end else if (wrap) begin
            cnt_q          <= '0;
            cfg_q.period   <= req_period_i;
            cfg_q.on_ticks <= cap_on(duty_i, req_period_i, OFF);
        end else begin
            cnt_q <= cnt_q + tick_t'(1);
        end
    end

    assign cnt_o = cnt_q;
    assign cfg_o = cfg_q;

    p_count_bounded_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_q < cfg_q.period);

    p_on_capped_r4: assert property (@(posedge clk) disable iff (rst)
        cfg_q.on_ticks <= cfg_q.period - OFF);

    p_cfg_held_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |-> $stable(cfg_q));

endmodule

// File: rtl/sync_pwm_timebase.sv
module sync_pwm_timebase
    import sync_pwm_pkg::*;
#(
    parameter int MIN_TICKS   = 20,
    parameter int MAX_TICKS   = 48,
    parameter int DEF_TICKS   = 30,
    parameter int OFF_TICKS   = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              role_master_i,
    input  logic              en_i,
    input  logic              use_default_i,
    input  logic [TICK_W-1:0] period_i,
    input  logic [TICK_W-1:0] duty_i,
    input  logic              sync_in_i,
    output logic              sync_out_o,
    output logic              sync_oe_o,
    output logic              hs_on_o,
    output logic              cyc_start_o,
    output logic              sync_lost_o
);
    role_e      role;
    tick_t      req_period;
    logic       edge_w;
    logic       locked_w;
    logic       restart_w;
    logic       run_w;
    tick_t      cnt_w;
    cycle_cfg_t cfg_w;

    assign role       = role_e'(role_master_i);
    assign req_period = use_default_i ? tick_t'(DEF_TICKS)
                      : clamp_ticks(period_i, tick_t'(MIN_TICKS), tick_t'(MAX_TICKS));
    assign restart_w  = (role == ROLE_SLAVE) && edge_w;

    sync_lock_mon #(
        .SYNC_STAGES(SYNC_STAGES)
    ) i_lock (
        .clk      (clk),
        .rst      (rst),
        .sync_in  (sync_in_i),
        .period   (cfg_w.period),
        .edge_o   (edge_w),
        .locked_o (locked_w)
    );

    pwm_period_ctr #(
        .DEF_TICKS(DEF_TICKS),
        .OFF_TICKS(OFF_TICKS)
    ) i_ctr (
        .clk          (clk),
        .rst          (rst),
        .restart_i    (restart_w),
        .req_period_i (req_period),
        .duty_i       (duty_i),
        .cnt_o        (cnt_w),
        .cfg_o        (cfg_w)
    );

    assign run_w       = en_i && ((role == ROLE_MASTER) || locked_w);
    assign hs_on_o     = run_w && (cnt_w < cfg_w.on_ticks);
    assign cyc_start_o = (cnt_w == '0);
    assign sync_oe_o   = (role == ROLE_MASTER);
    assign sync_out_o  = (role == ROLE_MASTER) && (cnt_w < (cfg_w.period >> 1));
    assign sync_lost_o = (role == ROLE_SLAVE) && !locked_w;

    p_hs_blocked_r8: assert property (@(posedge clk) disable iff (rst)
        sync_lost_o |-> !hs_on_o);

    p_restart_r7: assert property (@(posedge clk) disable iff (rst)
        restart_w |=> (cnt_w == '0));

    p_single_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        (cyc_start_o && !restart_w) |=> !cyc_start_o);

    p_off_gate_r6: assert property (@(posedge clk) disable iff (rst)
        !en_i |-> !hs_on_o);

endmodule

// File: tb/test_sync_pwm_timebase.sv
module test_sync_pwm_timebase;

    localparam int MINP = 20;
    localparam int MAXP = 48;
    localparam int DEFP = 30;
    localparam int OFFP = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        role_master = 1'b1;
    logic        en = 1'b1;
    logic        use_def = 1'b1;
    logic [15:0] period_in = 16'd30;
    logic [15:0] duty_in = 16'd10;
    logic        sync_in = 1'b0;
    logic        sync_out, sync_oe, hs_on, cyc_start, sync_lost;

    always #10 clk = ~clk;

    sync_pwm_timebase i_sync_pwm_timebase (
        .clk           (clk),
        .rst           (rst),
        .role_master_i (role_master),
        .en_i          (en),
        .use_default_i (use_def),
        .period_i      (period_in),
        .duty_i        (duty_in),
        .sync_in_i     (sync_in),
        .sync_out_o    (sync_out),
        .sync_oe_o     (sync_oe),
        .hs_on_o       (hs_on),
        .cyc_start_o   (cyc_start),
        .sync_lost_o   (sync_lost)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // ---------------- sync line generator ----------------
    bit gen_on = 0;
    int sync_per = 30;
    int gcnt = 0;
    int rise_cnt = 0;

    always @(posedge clk) begin
        bit nv;
        #1;
        if (gen_on) begin
            gcnt = (gcnt + 1) % sync_per;
            nv = (gcnt < sync_per / 2);
        end else begin
            gcnt = 0;
            nv = 0;
        end
        if (nv && !sync_in) rise_cnt++;
        sync_in = nv;
    end

    // ---------------- reference model ----------------
    int m_cnt = 0, m_per = DEFP, m_on = 0, m_since = 0, m_good = 0;
    bit q0 = 0, q1 = 0, q2 = 0;
    bit started = 0;

    function automatic int eff_period(bit ud, int p);
        if (ud) return DEFP;
        if (p < MINP) return MINP;
        if (p > MAXP) return MAXP;
        return p;
    endfunction

    always @(posedge clk) begin
        bit ed;
        int lim, np;
        started = 1;
        if (rst) begin
            m_cnt = 0; m_per = DEFP; m_on = 0; m_since = 0; m_good = 0;
            q0 = 0; q1 = 0; q2 = 0;
        end else begin
            ed  = q1 && !q2;
            lim = m_per + m_per / 2;
            if (ed) begin
                m_good  = (m_since >= lim || m_good == 0) ? 1 : 2;
                m_since = 0;
            end else if (m_since >= lim) begin
                m_good = 0;
            end else begin
                m_since++;
            end
            if ((!role_master && ed) || m_cnt >= m_per - 1) begin
                np    = eff_period(use_def, int'(period_in));
                m_on  = (int'(duty_in) > np - OFFP) ? np - OFFP : int'(duty_in);
                m_per = np;
                m_cnt = 0;
            end else begin
                m_cnt++;
            end
            q2 = q1; q1 = q0; q0 = sync_in;
        end
    end

    // ---------------- per-clock comparison and monitors ----------------
    int acc_len = 0, acc_on = 0, last_len = 0, last_on = 0, n_cyc = 0;
    int so_rise = 0, hs_total = 0;
    bit so_prev = 0;

    always @(negedge clk) begin
        bit e_lock, e_run, e_hs, e_cyc, e_so, e_lost;
        if (started) begin
            e_lock = (m_good == 2);
            e_run  = en && (role_master || e_lock);
            e_hs   = e_run && (m_cnt < m_on);
            e_cyc  = (m_cnt == 0);
            e_so   = role_master && (m_cnt < m_per / 2);
            e_lost = !role_master && !e_lock;
            chk(cyc_start == e_cyc, "R2 cyc_start_o", cyc_start, e_cyc);
            chk(hs_on == e_hs, "R4 hs_on_o", hs_on, e_hs);
            chk(sync_out == e_so, "R5 sync_out_o", sync_out, e_so);
            chk(sync_oe == role_master, "R5 sync_oe_o", sync_oe, role_master);
            chk(sync_lost == e_lost, "R8 sync_lost_o", sync_lost, e_lost);
        end
        if (cyc_start) begin
            last_len = acc_len; last_on = acc_on;
            acc_len = 1; acc_on = hs_on ? 1 : 0;
            n_cyc++;
        end else begin
            acc_len++;
            acc_on += hs_on ? 1 : 0;
        end
        if (sync_out && !so_prev) so_rise++;
        so_prev = sync_out;
        if (hs_on) hs_total++;
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", cycles, 0);
            summary();
        end
    end

    // ---------------- stimulus ----------------
    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic wait_cyc();
        int s;
        s = n_cyc;
        do step(1); while (n_cyc == s);
    endtask

    task automatic wait_rise();
        int s;
        s = rise_cnt;
        do step(1); while (rise_cnt == s);
    endtask

    initial begin
        int r0, h0;
        step(3);
        chk(hs_on == 0, "R1 hs_on_o low in reset", hs_on, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(cyc_start == 1, "R1 first clock is period start", cyc_start, 1);
        chk(hs_on == 0, "R1 no pulse in first clock", hs_on, 0);
        step(100);
        chk(last_len == DEFP, "R2 default period", last_len, DEFP);
        chk(last_on == 10, "R4 plain on-time", last_on, 10);

        use_def = 0; period_in = 48; duty_in = 60;
        step(150);
        chk(last_len == 48, "R2 longest period", last_len, 48);
        chk(last_on == 42, "R4 cap at longest period", last_on, 42);

        period_in = 5; duty_in = 17;
        step(100);
        chk(last_len == MINP, "R2 clamp low", last_len, MINP);
        chk(last_on == 14, "R4 cap at shortest period", last_on, 14);

        period_in = 100; duty_in = 3;
        step(150);
        chk(last_len == MAXP, "R2 clamp high", last_len, MAXP);
        chk(last_on == 3, "R4 short duty", last_on, 3);

        period_in = 48; duty_in = 20;
        step(120);
        wait_cyc();
        step(5);
        duty_in = 40; period_in = 24;
        wait_cyc();
        chk(last_on == 20, "R3 mid-period duty change deferred", last_on, 20);
        chk(last_len == 48, "R3 mid-period period change deferred", last_len, 48);
        wait_cyc();
        chk(last_on == 18, "R3 new settings next period", last_on, 18);
        chk(last_len == 24, "R3 new period next period", last_len, 24);

        // master disabled keeps the sync clock
        period_in = 48; duty_in = 20; en = 0;
        step(60);
        r0 = so_rise; h0 = hs_total;
        step(200);
        chk(so_rise - r0 >= 4, "R6 disabled master keeps sync", so_rise - r0, 4);
        chk(hs_total == h0, "R6 disabled master no pulse", hs_total - h0, 0);

        // master ignores the sync line
        en = 1; use_def = 1; duty_in = 12; sync_per = 17; gen_on = 1;
        step(150);
        chk(last_len == DEFP, "R7 master ignores sync_in_i", last_len, DEFP);
        gen_on = 0;
        step(5);

        // slave bring-up
        role_master = 0; sync_per = 30;
        step(60);
        chk(sync_lost == 1, "R8 slave lost without clock", sync_lost, 1);
        chk(sync_oe == 0 && sync_out == 0, "R5 slave does not drive", sync_oe + sync_out, 0);
        gen_on = 1;
        wait_rise();
        step(3);
        chk(sync_lost == 1, "R9 one edge is not enough", sync_lost, 1);
        wait_rise();
        step(3);
        chk(sync_lost == 0, "R9 locked after second edge", sync_lost, 0);
        chk(cyc_start == 1, "R7 edge restarts period", cyc_start, 1);
        step(150);
        chk(last_len == 30, "R7 slave period follows sync", last_len, 30);
        chk(last_on == 12, "R4 slave on-time", last_on, 12);

        sync_per = 28;
        step(150);
        chk(last_len == 28, "R7 slave restarts on faster sync", last_len, 28);

        // slave disabled
        en = 0;
        h0 = hs_total;
        step(100);
        chk(hs_total == h0, "R6 disabled slave no pulse", hs_total - h0, 0);
        en = 1;

        // loss and recovery
        gen_on = 0;
        h0 = hs_total;
        step(60);
        chk(sync_lost == 1, "R8 loss detected", sync_lost, 1);
        step(40);
        h0 = hs_total;
        step(40);
        chk(hs_total == h0, "R8 no pulse while lost", hs_total - h0, 0);
        sync_per = 30; gen_on = 1;
        wait_rise();
        step(3);
        chk(sync_lost == 1, "R9 relock needs second edge", sync_lost, 1);
        wait_rise();
        step(3);
        chk(sync_lost == 0, "R9 relocked", sync_lost, 0);
        step(100);

        summary();
    end

endmodule